// File: doc/BRIEF.md
# Processor Mode and Bank Register Controller

This block keeps the architectural state of a 16-bit processor core that depends on the operating mode. That state is the emulation flag, four status bits (M, X, D, I), the stack pointer, the two index registers, the accumulator, and two 8-bit bank registers: one for program code and one for data. The rest of the core writes this state through per-register write enables. The block enforces the width rules of each mode by itself.

Two kinds of event take priority over ordinary writes. The first is a mode-switch request. Entering emulation mode narrows the index registers and pins the stack to its fixed page. Leaving emulation mode changes only the flag. The second is interrupt entry, which covers hardware interrupts and the two software break instructions. It clears the bank registers, switches arithmetic to binary and masks further interrupts. In native mode only, it also asks the stack sequencer to push the program bank value that was just cleared. All outputs are registered. An event sampled on a clock edge is visible right after that edge.

Top module: `mode_bank_ctrl`

## Requirements
- R1: After reset the block is in emulation mode. Flags M=1, X=1, D=0, I=1. SP=0x01FF. X, Y, A, program bank and data bank are all zero. No push request is raised.
- R2: A request to enter emulation mode sets M and X to 1, sets the SP high byte to 0x01 and clears the high bytes of X and Y. The low bytes of SP, X and Y, all of A, and the D and I flags keep their values.
- R3: A request to enter native mode clears the emulation flag and leaves every other register and flag unchanged.
- R4: While in emulation mode, a status write cannot clear M or X. An SP write stores only its low byte, and the high byte stays 0x01.
- R5: While the X flag is 1, the high bytes of X and Y are 0x00. This holds for index writes, and it also holds on the edge where a status write sets X.
- R6: Interrupt entry in native mode clears the program bank and keeps the data bank. On the same edge it raises the push request for one cycle, with the old program bank value on the push data output.
- R7: Interrupt entry in emulation mode clears both bank registers and raises no push request.
- R8: Interrupt entry in either mode clears D and sets I, on the same edge as the bank clear.
- R9: Interrupt entry wins over a mode request in the same cycle, and the mode request is dropped. Any register write presented in the same cycle as interrupt entry or a mode request is ignored.
- R10: In native mode with M=0 and X=0, writes store all 16 bits of SP, X and Y. Accumulator writes always store all 16 bits, whatever the mode or the M flag. The status word carries M in bit 3, X in bit 2, D in bit 1 and I in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_entry | input | 1 | One-cycle pulse: hardware interrupt, break or coprocessor-trap entry |
| mode_req | input | 1 | Mode-switch request strobe |
| mode_req_emu | input | 1 | Target mode of the request: 1 emulation, 0 native |
| wr_flags_en | input | 1 | Write enable for the status bits |
| wr_flags | input | 4 | New status bits {M,X,D,I} |
| wr_sp_en | input | 1 | Stack pointer write enable |
| wr_x_en | input | 1 | X index write enable |
| wr_y_en | input | 1 | Y index write enable |
| wr_a_en | input | 1 | Accumulator write enable |
| wr_word | input | 16 | Write data for SP, X, Y and A |
| wr_pbr_en | input | 1 | Program bank write enable |
| wr_dbr_en | input | 1 | Data bank write enable |
| wr_bank | input | 8 | Write data for the bank registers |
| emu_mode | output | 1 | Emulation flag |
| flags_o | output | 4 | Status bits {M,X,D,I} |
| sp_o | output | 16 | Stack pointer |
| x_o | output | 16 | X index register |
| y_o | output | 16 | Y index register |
| a_o | output | 16 | Accumulator |
| pbr_o | output | 8 | Program bank register |
| dbr_o | output | 8 | Data bank register |
| pbr_push_req | output | 1 | One-cycle request to push the old program bank |
| pbr_push_data | output | 8 | Program bank value to push |

## Verification
The hardest case to reach is a collision. Interrupt entry, a mode request and register writes all arrive on the same edge, from a native state whose bank and index registers hold non-zero values. That state has to be built first with a mode switch and full-width writes. The bench then applies the colliding strobes together in one cycle and checks the result. The mode must stay native, the program bank must clear with its old value on the push port, and every register the writes aimed at must be unchanged. A second hard case is a status write that raises X while the index registers hold wide values. It is reached by writing 16-bit indexes in native mode first.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef struct packed {
    logic m;
    logic x;
    logic d;
    logic i;
  } mbc_flags_t;

  typedef enum logic [1:0] {
    EV_IDLE      = 2'd0,
    EV_IRQ       = 2'd1,
    EV_TO_EMU    = 2'd2,
    EV_TO_NATIVE = 2'd3
  } mbc_event_e;

  function automatic mbc_event_e mbc_classify(input logic irq, input logic req,
                                              input logic to_emu);
    if (irq)      return EV_IRQ;
    else if (req) return to_emu ? EV_TO_EMU : EV_TO_NATIVE;
    else          return EV_IDLE;
  endfunction

endpackage

// File: rtl/mbc_rst_sync.sv
module mbc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/mbc_status_regs.sv
module mbc_status_regs
  import mbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mbc_event_e ev,
  input  logic       wr_en,
  input  mbc_flags_t wr_val,
  output logic       emu_q,
  output logic       emu_nxt,
  output mbc_flags_t flags_q,
  output mbc_flags_t flags_nxt
);
  logic en;

  always_comb begin
    emu_nxt   = emu_q;
    flags_nxt = flags_q;
    unique case (ev)
      EV_IRQ: begin
        flags_nxt.d = 1'b0;
        flags_nxt.i = 1'b1;
      end
      EV_TO_EMU: begin
        emu_nxt     = 1'b1;
        flags_nxt.m = 1'b1;
        flags_nxt.x = 1'b1;
      end
      EV_TO_NATIVE: emu_nxt = 1'b0;
      default: if (wr_en) flags_nxt = wr_val;
    endcase
    if (emu_nxt) begin
      flags_nxt.m = 1'b1;
      flags_nxt.x = 1'b1;
    end
  end

  assign en = (ev != EV_IDLE) || wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emu_q   <= 1'b1;
      flags_q <= '{m: 1'b1, x: 1'b1, d: 1'b0, i: 1'b1};
    end else if (en) begin
      emu_q   <= emu_nxt;
      flags_q <= flags_nxt;
    end
  end
endmodule

// File: rtl/mbc_width_regs.sv
module mbc_width_regs #(
  parameter int DATA_W  = 16,
  parameter int SP_PAGE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              emu_nxt,
  input  logic              xflag_nxt,
  input  logic              wr_sp_en,
  input  logic              wr_x_en,
  input  logic              wr_y_en,
  input  logic              wr_a_en,
  input  logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] sp_q,
  output logic [DATA_W-1:0] x_q,
  output logic [DATA_W-1:0] y_q,
  output logic [DATA_W-1:0] a_q
);
  localparam int HALF = DATA_W / 2;
  localparam int NIDX = 2;
  localparam logic [HALF-1:0] PAGE = HALF'(SP_PAGE);

  logic [DATA_W-1:0] sp_nxt, a_nxt;
  logic [NIDX-1:0]   idx_wr;
  logic [DATA_W-1:0] idx_q   [NIDX];
  logic [DATA_W-1:0] idx_nxt [NIDX];

  assign idx_wr = {wr_y_en, wr_x_en};

  always_comb begin
    sp_nxt = (wr_ok && wr_sp_en) ? wr_word : sp_q;
    if (emu_nxt) sp_nxt[DATA_W-1:HALF] = PAGE;
    a_nxt = (wr_ok && wr_a_en) ? wr_word : a_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= {PAGE, {HALF{1'b1}}};
      a_q  <= '0;
    end else begin
      sp_q <= sp_nxt;
      if (wr_ok && wr_a_en) a_q <= a_nxt;
    end
  end

  for (genvar g = 0; g < NIDX; g++) begin : g_idx
    always_comb begin
      idx_nxt[g] = (wr_ok && idx_wr[g]) ? wr_word : idx_q[g];
      if (xflag_nxt) idx_nxt[g][DATA_W-1:HALF] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q[g] <= '0;
      else        idx_q[g] <= idx_nxt[g];
    end
  end

  assign x_q = idx_q[0];
  assign y_q = idx_q[1];
endmodule

// File: rtl/mbc_bank_regs.sv
module mbc_bank_regs
  import mbc_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mbc_event_e        ev,
  input  logic              emu_q,
  input  logic              wr_ok,
  input  logic              wr_pbr_en,
  input  logic              wr_dbr_en,
  input  logic [BANK_W-1:0] wr_bank,
  output logic [BANK_W-1:0] pbr_q,
  output logic [BANK_W-1:0] dbr_q,
  output logic              push_q,
  output logic [BANK_W-1:0] push_data_q
);
  logic [BANK_W-1:0] pbr_nxt, dbr_nxt;
  logic              push_nxt;
  logic              save_en;

  always_comb begin
    pbr_nxt  = pbr_q;
    dbr_nxt  = dbr_q;
    push_nxt = 1'b0;
    if (ev == EV_IRQ) begin
      pbr_nxt  = '0;
      if (emu_q) dbr_nxt  = '0;
      else       push_nxt = 1'b1;
    end else if (wr_ok) begin
      if (wr_pbr_en) pbr_nxt = wr_bank;
      if (wr_dbr_en) dbr_nxt = wr_bank;
    end
  end

  assign save_en = push_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pbr_q       <= '0;
      dbr_q       <= '0;
      push_q      <= 1'b0;
      push_data_q <= '0;
    end else begin
      pbr_q  <= pbr_nxt;
      dbr_q  <= dbr_nxt;
      push_q <= push_nxt;
      if (save_en) push_data_q <= pbr_q;
    end
  end
endmodule

// File: rtl/mode_bank_ctrl.sv
module mode_bank_ctrl
  import mbc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BANK_W  = 8,
  parameter int SP_PAGE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_entry,
  input  logic              mode_req,
  input  logic              mode_req_emu,
  input  logic              wr_flags_en,
  input  logic [3:0]        wr_flags,
  input  logic              wr_sp_en,
  input  logic              wr_x_en,
  input  logic              wr_y_en,
  input  logic              wr_a_en,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              wr_pbr_en,
  input  logic              wr_dbr_en,
  input  logic [BANK_W-1:0] wr_bank,
  output logic              emu_mode,
  output logic [3:0]        flags_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] x_o,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] a_o,
  output logic [BANK_W-1:0] pbr_o,
  output logic [BANK_W-1:0] dbr_o,
  output logic              pbr_push_req,
  output logic [BANK_W-1:0] pbr_push_data
);
  logic       rst_sync_n;
  mbc_event_e ev;
  logic       wr_ok;
  logic       emu_q, emu_nxt;
  mbc_flags_t flags_q, flags_nxt;

  mbc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ev    = mbc_classify(irq_entry, mode_req, mode_req_emu);
  assign wr_ok = (ev == EV_IDLE);

  mbc_status_regs u_status (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ev        (ev),
    .wr_en     (wr_ok && wr_flags_en),
    .wr_val    (mbc_flags_t'(wr_flags)),
    .emu_q     (emu_q),
    .emu_nxt   (emu_nxt),
    .flags_q   (flags_q),
    .flags_nxt (flags_nxt)
  );

  mbc_width_regs #(.DATA_W(DATA_W), .SP_PAGE(SP_PAGE)) u_width (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_ok     (wr_ok),
    .emu_nxt   (emu_nxt),
    .xflag_nxt (flags_nxt.x),
    .wr_sp_en  (wr_sp_en),
    .wr_x_en   (wr_x_en),
    .wr_y_en   (wr_y_en),
    .wr_a_en   (wr_a_en),
    .wr_word   (wr_word),
    .sp_q      (sp_o),
    .x_q       (x_o),
    .y_q       (y_o),
    .a_q       (a_o)
  );

  mbc_bank_regs #(.BANK_W(BANK_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ev          (ev),
    .emu_q       (emu_q),
    .wr_ok       (wr_ok),
    .wr_pbr_en   (wr_pbr_en),
    .wr_dbr_en   (wr_dbr_en),
    .wr_bank     (wr_bank),
    .pbr_q       (pbr_o),
    .dbr_q       (dbr_o),
    .push_q      (pbr_push_req),
    .push_data_q (pbr_push_data)
  );

  assign emu_mode = emu_q;
  assign flags_o  = flags_q;
endmodule

// File: rtl/mbc_checker.sv
module mbc_checker #(
  parameter int DATA_W  = 16,
  parameter int BANK_W  = 8,
  parameter int SP_PAGE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_entry,
  input logic              mode_req,
  input logic              mode_req_emu,
  input logic              emu_mode,
  input logic [3:0]        flags_o,
  input logic [DATA_W-1:0] sp_o,
  input logic [DATA_W-1:0] x_o,
  input logic [DATA_W-1:0] y_o,
  input logic [DATA_W-1:0] a_o,
  input logic [BANK_W-1:0] pbr_o,
  input logic [BANK_W-1:0] dbr_o,
  input logic              pbr_push_req,
  input logic [BANK_W-1:0] pbr_push_data
);
  localparam int HALF = DATA_W / 2;
  localparam logic [HALF-1:0] PAGE = HALF'(SP_PAGE);

  p_emu_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    emu_mode |-> (flags_o[3] && flags_o[2] && sp_o[DATA_W-1:HALF] == PAGE));

  p_narrow_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[2] |-> (x_o[DATA_W-1:HALF] == '0 && y_o[DATA_W-1:HALF] == '0));

  p_native_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_entry && !emu_mode) |=>
      (pbr_o == '0 && pbr_push_req && pbr_push_data == $past(pbr_o)
       && dbr_o == $past(dbr_o)));

  p_push_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pbr_push_req |-> ($past(irq_entry) && !$past(emu_mode)));

  p_emu_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_entry && emu_mode) |=> (pbr_o == '0 && dbr_o == '0 && !pbr_push_req));

  p_irq_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry |=> (!flags_o[1] && flags_o[0]));

  p_irq_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry |=> $stable(emu_mode));

  p_to_emu_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req && mode_req_emu && !irq_entry) |=>
      ($stable(a_o) && $stable(sp_o[HALF-1:0]) && $stable(x_o[HALF-1:0])
       && $stable(y_o[HALF-1:0]) && $stable(flags_o[1:0])));

  p_to_native_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req && !mode_req_emu && !irq_entry) |=>
      (!emu_mode && $stable(flags_o) && $stable(sp_o) && $stable(x_o)
       && $stable(y_o) && $stable(a_o) && $stable(pbr_o) && $stable(dbr_o)));
endmodule

bind mode_bank_ctrl mbc_checker #(.DATA_W(DATA_W), .BANK_W(BANK_W), .SP_PAGE(SP_PAGE)) u_mbc_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .irq_entry     (irq_entry),
  .mode_req      (mode_req),
  .mode_req_emu  (mode_req_emu),
  .emu_mode      (emu_mode),
  .flags_o       (flags_o),
  .sp_o          (sp_o),
  .x_o           (x_o),
  .y_o           (y_o),
  .a_o           (a_o),
  .pbr_o         (pbr_o),
  .dbr_o         (dbr_o),
  .pbr_push_req  (pbr_push_req),
  .pbr_push_data (pbr_push_data)
);

// File: tb/mode_bank_ctrl_bench.sv
module mode_bank_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_entry, mode_req, mode_req_emu;
  logic        wr_flags_en, wr_sp_en, wr_x_en, wr_y_en, wr_a_en, wr_pbr_en, wr_dbr_en;
  logic [3:0]  wr_flags;
  logic [15:0] wr_word;
  logic [7:0]  wr_bank;
  logic        emu_mode, pbr_push_req;
  logic [3:0]  flags_o;
  logic [15:0] sp_o, x_o, y_o, a_o;
  logic [7:0]  pbr_o, dbr_o, pbr_push_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mode_bank_ctrl u_mode_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_entry(irq_entry), .mode_req(mode_req),
    .mode_req_emu(mode_req_emu), .wr_flags_en(wr_flags_en), .wr_flags(wr_flags),
    .wr_sp_en(wr_sp_en), .wr_x_en(wr_x_en), .wr_y_en(wr_y_en), .wr_a_en(wr_a_en),
    .wr_word(wr_word), .wr_pbr_en(wr_pbr_en), .wr_dbr_en(wr_dbr_en), .wr_bank(wr_bank),
    .emu_mode(emu_mode), .flags_o(flags_o), .sp_o(sp_o), .x_o(x_o), .y_o(y_o),
    .a_o(a_o), .pbr_o(pbr_o), .dbr_o(dbr_o), .pbr_push_req(pbr_push_req),
    .pbr_push_data(pbr_push_data)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    irq_entry = 0; mode_req = 0; mode_req_emu = 0;
    wr_flags_en = 0; wr_sp_en = 0; wr_x_en = 0; wr_y_en = 0; wr_a_en = 0;
    wr_pbr_en = 0; wr_dbr_en = 0; wr_flags = '0; wr_word = '0; wr_bank = '0;
  endtask

  // inputs are set at a falling edge; one rising edge later, sample at the next falling edge
  task automatic tick();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_mode(input logic to_emu);
    mode_req = 1; mode_req_emu = to_emu; tick();
  endtask

  task automatic do_flags(input logic [3:0] f);
    wr_flags_en = 1; wr_flags = f; tick();
  endtask

  task automatic do_word(input logic sp, input logic x, input logic y,
                         input logic a, input logic [15:0] w);
    wr_sp_en = sp; wr_x_en = x; wr_y_en = y; wr_a_en = a; wr_word = w; tick();
  endtask

  task automatic do_bank(input logic p, input logic d, input logic [7:0] b);
    wr_pbr_en = p; wr_dbr_en = d; wr_bank = b; tick();
  endtask

  task automatic t_reset();
    check("R1", "emu", emu_mode, 1);
    check("R1", "flags", flags_o, 4'b1101);
    check("R1", "sp", sp_o, 16'h01FF);
    check("R1", "x", x_o, 0);
    check("R1", "y", y_o, 0);
    check("R1", "a", a_o, 0);
    check("R1", "pbr", pbr_o, 0);
    check("R1", "dbr", dbr_o, 0);
    check("R1", "push", pbr_push_req, 0);
  endtask

  task automatic t_native_full();
    do_mode(0);
    check("R3", "emu", emu_mode, 0);
    check("R3", "flags", flags_o, 4'b1101);
    check("R3", "sp", sp_o, 16'h01FF);
    do_flags(4'b0010);
    check("R10", "flags", flags_o, 4'b0010);
    do_word(1, 0, 0, 0, 16'h1234);
    do_word(0, 1, 0, 0, 16'hABCD);
    do_word(0, 0, 1, 0, 16'h5678);
    do_word(0, 0, 0, 1, 16'h9ABC);
    do_bank(1, 0, 8'h12);
    do_bank(0, 1, 8'h34);
    check("R10", "sp", sp_o, 16'h1234);
    check("R10", "x", x_o, 16'hABCD);
    check("R10", "y", y_o, 16'h5678);
    check("R10", "a", a_o, 16'h9ABC);
    irq_entry = 1; tick();
    check("R6", "pbr", pbr_o, 0);
    check("R6", "dbr", dbr_o, 8'h34);
    check("R6", "push", pbr_push_req, 1);
    check("R6", "push data", pbr_push_data, 8'h12);
    check("R8", "flags", flags_o, 4'b0001);
    tick();
    check("R6", "push drops", pbr_push_req, 0);
  endtask

  task automatic t_to_emu();
    do_mode(1);
    check("R2", "emu", emu_mode, 1);
    check("R2", "flags", flags_o, 4'b1101);
    check("R2", "sp", sp_o, 16'h0134);
    check("R2", "x", x_o, 16'h00CD);
    check("R2", "y", y_o, 16'h0078);
    check("R2", "a", a_o, 16'h9ABC);
  endtask

  task automatic t_emu_writes();
    do_flags(4'b0000);
    check("R4", "flags", flags_o, 4'b1100);
    do_word(1, 0, 0, 0, 16'h7766);
    check("R4", "sp", sp_o, 16'h0166);
    do_word(0, 1, 1, 1, 16'hFFEE);
    check("R5", "x", x_o, 16'h00EE);
    check("R5", "y", y_o, 16'h00EE);
    check("R10", "a in emu", a_o, 16'hFFEE);
  endtask

  task automatic t_emu_irq();
    do_bank(1, 1, 8'h55);
    do_flags(4'b0010);
    irq_entry = 1; tick();
    check("R7", "pbr", pbr_o, 0);
    check("R7", "dbr", dbr_o, 0);
    check("R7", "push", pbr_push_req, 0);
    check("R8", "flags", flags_o, 4'b1101);
  endtask

  task automatic t_xflag_raise();
    do_mode(0);
    do_flags(4'b0000);
    do_word(0, 1, 1, 0, 16'h1234);
    check("R10", "x wide", x_o, 16'h1234);
    do_flags(4'b0100);
    check("R5", "x narrowed", x_o, 16'h0034);
    check("R5", "y narrowed", y_o, 16'h0034);
    do_flags(4'b0000);
  endtask

  task automatic t_collide();
    do_bank(1, 1, 8'h77);
    do_word(0, 0, 0, 1, 16'h4321);
    irq_entry = 1; mode_req = 1; mode_req_emu = 1;
    wr_pbr_en = 1; wr_dbr_en = 1; wr_bank = 8'h99;
    wr_a_en = 1; wr_word = 16'hBEEF;
    tick();
    check("R9", "emu", emu_mode, 0);
    check("R9", "pbr", pbr_o, 0);
    check("R9", "dbr", dbr_o, 8'h77);
    check("R9", "push data", pbr_push_data, 8'h77);
    check("R9", "a", a_o, 16'h4321);
    mode_req = 1; mode_req_emu = 0; wr_x_en = 1; wr_word = 16'hCAFE; tick();
    check("R9", "x under mode req", x_o, 16'h0034);
    check("R9", "flags", flags_o, 4'b0001);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_native_full();
    t_to_emu();
    t_emu_writes();
    t_emu_irq();
    t_xflag_raise();
    t_collide();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule